// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer execute stage of a small load-store RISC core. Each cycle it takes an operation code, a first operand, a second operand that has already passed through the core's barrel shifter, the shifter's carry-out together with a bit saying whether a shift was actually applied, the current N/Z/C/V condition flags and a request to update those flags. It produces the 32-bit data result, a write strobe for the destination register and the next value of the four flags.

The block handles four classes of operation. Arithmetic covers forward and reverse subtraction, each with and without carry. Bitwise logic includes a bit-clear. Moves pass the second operand or its inverse. Compare/test operations only set the flags. Arithmetic carries and signed overflow never widen the result; they only reach the flags. Every output is registered, so a result appears one clock after its operands, which fits a pipeline that writes back in the following stage.

Top module: `dp_alu`

## Requirements
- R1: Arithmetic codes give these results modulo 2^32, with Cin = flags_in[1]: ADD (4) a+b, ADC (5) a+b+Cin, SUB (2) a-b, SBC (6) a-b-(1-Cin), RSB (3) b-a, RSC (7) b-a-(1-Cin).
- R2: Logic codes give these results: AND (0) and TST (8) a&b, EOR (1) and TEQ (9) a^b, ORR (12) a|b, BIC (14) a&~b.
- R3: MOV (13) gives b and MVN (15) gives ~b; operand a has no effect on the result.
- R4: Compare codes 8 to 11 (TST, TEQ, CMP = a-b, CMN = a+b) hold wr_en low and update the flags even when set_flags is low. result still reports the value they computed. Every other code drives wr_en high.
- R5: For codes outside 8 to 11 with set_flags low, flags_out equals flags_in. The flag bits are ordered N=[3], Z=[2], C=[1], V=[0].
- R6: When arithmetic codes (2 to 7, 10, 11) update the flags, N is result bit 31 and Z is set when the result is zero. For additions C is the carry out of bit 31; for subtractions C is 1 when no borrow occurs. V is set on signed two's-complement overflow.
- R7: When logic and move codes update the flags, N and Z follow the result and V keeps its input value. C takes shift_carry when shift_applied is high and otherwise keeps its input value.
- R8: All outputs are registered. Inputs sampled at a rising clock edge show up on the outputs just after that edge and stay stable until the next edge.
- R9: A synchronous active-high reset clears result, wr_en and flags_out to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand after the shifter |
| shift_carry | input | 1 | Carry-out from the shifter |
| shift_applied | input | 1 | High when the shifter actually shifted b |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| set_flags | input | 1 | Flag-update request for non-compare codes |
| result | output | WIDTH | Registered data result |
| wr_en | output | 1 | Registered destination write strobe |
| flags_out | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
The checker assumes every input is at a known value at each sampling edge, and that nothing changes near the edge. Its properties relate the registered outputs to the inputs of the previous cycle, and they are only evaluated once a full cycle outside reset has passed. The bench changes inputs only on falling edges and samples one time unit after the rising edge. Random operands are biased toward zero, all-ones, the sign boundary values and the largest positive value, so that carry, borrow and overflow cases appear often while every input stays driven.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic op_is_cmp(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_arith(input logic [3:0] op);
    logic r;
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC,
      OP_SBC, OP_RSC, OP_CMP, OP_CMN: r = 1'b1;
      default:                        r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             v_out
);
  localparam int MSB = WIDTH - 1;

  logic             swap;
  logic             invert;
  logic             carry0;
  logic [WIDTH-1:0] x;
  logic [WIDTH-1:0] y_raw;
  logic [WIDTH-1:0] y;
  logic [WIDTH:0]   full;

  always_comb begin
    swap   = (op == OP_RSB) || (op == OP_RSC);
    invert = (op == OP_SUB) || (op == OP_RSB) || (op == OP_SBC) ||
             (op == OP_RSC) || (op == OP_CMP);
    case (op)
      OP_ADC, OP_SBC, OP_RSC: carry0 = c_in;
      default:                carry0 = invert;
    endcase
    x     = swap ? b : a;
    y_raw = swap ? a : b;
    y     = invert ? ~y_raw : y_raw;
    full  = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, carry0};
    sum   = full[MSB:0];
    c_out = full[WIDTH];
    v_out = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
  end

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             shift_carry,
  input  logic             shift_applied,
  input  logic [3:0]       flags_in,
  input  logic             set_flags,
  output logic [WIDTH-1:0] result,
  output logic             wr_en,
  output logic [3:0]       flags_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] arith_sum;
  logic             arith_c;
  logic             arith_v;
  logic [WIDTH-1:0] logic_res;
  logic [WIDTH-1:0] res_d;
  logic             is_arith;
  logic             is_cmp;
  logic             upd;
  nzcv_t            cur;
  nzcv_t            nxt;

  dp_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op    (op),
    .a     (a),
    .b     (b),
    .c_in  (flags_in[1]),
    .sum   (arith_sum),
    .c_out (arith_c),
    .v_out (arith_v)
  );

  dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op  (op),
    .a   (a),
    .b   (b),
    .res (logic_res)
  );

  always_comb begin
    is_arith = op_is_arith(op);
    is_cmp   = op_is_cmp(op);
    upd      = is_cmp || set_flags;
    res_d    = is_arith ? arith_sum : logic_res;
    cur      = nzcv_t'(flags_in);
    nxt      = cur;
    if (upd) begin
      nxt.n = res_d[MSB];
      nxt.z = (res_d == '0);
      if (is_arith) begin
        nxt.c = arith_c;
        nxt.v = arith_v;
      end else if (shift_applied) begin
        nxt.c = shift_carry;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      wr_en     <= 1'b0;
      flags_out <= '0;
    end else begin
      result    <= res_d;
      wr_en     <= !is_cmp;
      flags_out <= nxt;
    end
  end

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op,
  input logic             shift_carry,
  input logic             shift_applied,
  input logic [3:0]       flags_in,
  input logic             set_flags,
  input logic [WIDTH-1:0] result,
  input logic             wr_en,
  input logic [3:0]       flags_out
);
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  logic was_cmp;
  logic was_logic;
  assign was_cmp   = (op[3:2] == 2'b10);
  assign was_logic = (op == 4'd0) || (op == 4'd1) || (op >= 4'd12);

  // R4
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && $past(was_cmp) |-> !wr_en);

  // R4
  alu_write_chk: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && !$past(was_cmp) |-> wr_en);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && !$past(was_cmp) && !$past(set_flags)
    |-> flags_out == $past(flags_in));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && ($past(was_cmp) || $past(set_flags))
    |-> flags_out[2] == (result == '0) && flags_out[3] == result[WIDTH-1]);

  // R7
  logic_v_keep_chk: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && $past(was_logic) && $past(set_flags)
    |-> flags_out[0] == $past(flags_in[0]));

  // R7
  logic_c_shift_chk: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && $past(was_logic) && $past(set_flags) && $past(shift_applied)
    |-> flags_out[1] == $past(shift_carry));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    primed && $past(rst) |-> !wr_en && flags_out == 4'd0 && result == '0);

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .op            (op),
  .shift_carry   (shift_carry),
  .shift_applied (shift_applied),
  .flags_in      (flags_in),
  .set_flags     (set_flags),
  .result        (result),
  .wr_en         (wr_en),
  .flags_out     (flags_out)
);

// File: tb/tb_dp_alu.sv
module tb_dp_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = '0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        shift_carry = 1'b0;
  logic        shift_applied = 1'b0;
  logic [3:0]  flags_in = '0;
  logic        set_flags = 1'b0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dp_alu dut (
    .clk(clk), .rst(rst), .op(op), .a(a), .b(b),
    .shift_carry(shift_carry), .shift_applied(shift_applied),
    .flags_in(flags_in), .set_flags(set_flags),
    .result(result), .wr_en(wr_en), .flags_out(flags_out)
  );

  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  function automatic logic [36:0] model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                                        input logic sc, input logic sh, input logic [3:0] fi, input logic sf);
    logic [31:0] r;
    logic n, z, c, v, ar, cm, c0, v0;
    longint ux, uy, sx, sy, m, t, sm, st, s, ss, bw;
    ux = longint'({32'd0, x}); uy = longint'({32'd0, y});
    sx = longint'($signed(x)); sy = longint'($signed(y));
    n = fi[3]; z = fi[2]; c = fi[1]; v = fi[0];
    ar = 1'b0; c0 = 1'b0; v0 = 1'b0; r = '0;
    cm = (o >= 4'd8) && (o <= 4'd11);
    case (o)
      4'd0, 4'd8:  r = x & y;
      4'd1, 4'd9:  r = x ^ y;
      4'd12:       r = x | y;
      4'd13:       r = y;
      4'd14:       r = x & ~y;
      4'd15:       r = ~y;
      4'd4, 4'd5, 4'd11: begin
        ar = 1'b1;
        bw = (o == 4'd5) ? longint'(fi[1]) : 64'sd0;
        s  = ux + uy + bw;
        r  = 32'(s);
        c0 = (s > 64'sd4294967295);
        ss = sx + sy + bw;
        v0 = (ss > SMAX) || (ss < SMIN);
      end
      default: begin
        ar = 1'b1;
        bw = ((o == 4'd6) || (o == 4'd7)) ? longint'(!fi[1]) : 64'sd0;
        if ((o == 4'd3) || (o == 4'd7)) begin
          m = uy; t = ux; sm = sy; st = sx;
        end else begin
          m = ux; t = uy; sm = sx; st = sy;
        end
        s  = m - t - bw;
        r  = 32'(s);
        c0 = (m >= t + bw);
        ss = sm - st - bw;
        v0 = (ss > SMAX) || (ss < SMIN);
      end
    endcase
    if (cm || sf) begin
      n = r[31];
      z = (r == 32'd0);
      if (ar) begin
        c = c0; v = v0;
      end else if (sh) begin
        c = sc;
      end
    end
    return {r, !cm, n, z, c, v};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                     input logic sc, input logic sh, input logic [3:0] fi, input logic sf);
    logic [36:0] e;
    string rtag, ftag;
    @(negedge clk);
    op = o; a = x; b = y; shift_carry = sc; shift_applied = sh; flags_in = fi; set_flags = sf;
    e = model(o, x, y, sc, sh, fi, sf);
    @(posedge clk);
    #1;
    if ((o >= 4'd2 && o <= 4'd7) || o == 4'd10 || o == 4'd11) rtag = "R1";
    else if (o == 4'd13 || o == 4'd15) rtag = "R3";
    else rtag = "R2";
    if (o >= 4'd8 && o <= 4'd11) ftag = "R4";
    else if (!sf) ftag = "R5";
    else if (o >= 4'd2 && o <= 4'd7) ftag = "R6";
    else ftag = "R7";
    check(rtag, "result", result, e[36:5]);
    check("R4", "wr_en", {31'd0, wr_en}, {31'd0, e[4]});
    check(ftag, "flags", {28'd0, flags_out}, {28'd0, e[3:0]});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0:       return 32'h0000_0000;
      1:       return 32'hFFFF_FFFF;
      2:       return 32'h8000_0000;
      3:       return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    op = 4'd4; a = 32'h1234; b = 32'h1; flags_in = 4'hF; set_flags = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R9", "reset result", result, 32'd0);
    check("R9", "reset wr_en", {31'd0, wr_en}, 32'd0);
    check("R9", "reset flags", {28'd0, flags_out}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1 / R6 directed corners
    run(4'd4, 32'h7FFF_FFFF, 32'd1, 0, 0, 4'h0, 1);   // signed overflow
    run(4'd4, 32'hFFFF_FFFF, 32'd1, 0, 0, 4'h0, 1);   // carry, zero
    run(4'd2, 32'd5, 32'd5, 0, 0, 4'h0, 1);           // equal: Z, C
    run(4'd2, 32'd0, 32'd1, 0, 0, 4'h0, 1);           // borrow
    run(4'd6, 32'd10, 32'd3, 0, 0, 4'h0, 1);          // SBC with C clear
    run(4'd7, 32'd3, 32'd10, 0, 0, 4'h2, 1);          // RSC with C set
    run(4'd5, 32'hFFFF_FFFF, 32'd0, 0, 0, 4'h2, 1);   // ADC wrap
    run(4'd3, 32'h8000_0000, 32'd0, 0, 0, 4'h0, 1);   // RSB overflow
    // R2 / R7
    run(4'd14, 32'hFFFF_00FF, 32'h0F0F_0F0F, 1, 1, 4'h1, 1);
    run(4'd12, 32'h0, 32'h0, 1, 0, 4'h3, 1);           // C kept without shift
    // R3: operand a ignored
    run(4'd13, 32'hDEAD_BEEF, 32'h1357_9BDF, 0, 0, 4'h0, 0);
    run(4'd13, 32'h0123_4567, 32'h1357_9BDF, 0, 0, 4'h0, 0);
    run(4'd15, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 0, 1, 4'h0, 1);
    // R4: compares update flags with set_flags low
    run(4'd8, 32'hF0, 32'h0F, 1, 1, 4'hD, 0);
    run(4'd10, 32'd7, 32'd9, 0, 0, 4'h0, 0);
    run(4'd11, 32'hFFFF_FFFF, 32'd1, 0, 0, 4'h0, 0);
    // R5: no update when set_flags low
    run(4'd4, 32'hFFFF_FFFF, 32'd1, 0, 0, 4'hA, 0);

    // R8: output holds until the next edge
    run(4'd4, 32'd1, 32'd2, 0, 0, 4'h0, 0);
    @(negedge clk);
    op = 4'd4; a = 32'd100; b = 32'd23;
    #1;
    check("R8", "held before edge", result, 32'd3);
    @(posedge clk);
    #1;
    check("R8", "after edge", result, 32'd123);

    for (int i = 0; i < 3000; i++) begin
      run(4'($urandom % 16), pick(), pick(), 1'($urandom), 1'($urandom),
          4'($urandom), 1'($urandom));
    end

    // R9: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R9", "mid reset flags", {28'd0, flags_out}, 32'd0);
    check("R9", "mid reset wr_en", {31'd0, wr_en}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule